// File: doc/BRIEF.md
# Tightly Coupled Memory Router

This block sits between a processor core's fetch port and data port and two private on-chip memories: an instruction memory that always starts at address zero and a data memory whose base can be moved. On every request it decides whether the address belongs to one of the two memories. On a hit it serves the access locally. On a miss it reports no hit, so the surrounding logic can send the access to the external bus instead. The enables, the data base and the two size codes come from the core's control registers as plain inputs.

A size code `c` selects a region of `512 << c` bytes. Codes of 23 and above are clamped to the full 4 GiB space. The instruction region repeats its memory contents every memory-size bytes. The data region starts at a 4 KiB aligned base, and the offset from that base wraps modulo the data memory size. The fetch port can reach only the instruction memory. The data port can reach both memories, and the instruction memory wins where the two regions overlap.

After reset the block writes zero into every word of both memories, one word per cycle. It ignores requests until that sequence has finished. The default memory sizes (4 KiB and 2 KiB) are kept small for elaboration. A full-size instance sets `I_AW=15`, `D_AW=14`.

Top module: `tcm_router`

## Requirements
- R1: After reset `init_done` is 0, and both memories are filled with zeros one word per cycle. `init_done` then rises and stays high until the next reset. Requests made while `init_done` is 0 produce no response and write nothing.
- R2: An address hits the instruction memory exactly when `cfg_imem_en` is 1 and the address is below `512 << cfg_imem_code` (4 GiB for codes of 23 and above). The memory location is the address modulo 2^I_AW, so contents repeat every 2^I_AW bytes.
- R3: A data address hits the data memory exactly when `cfg_dmem_en` is 1 and base <= address < base + `512 << cfg_dmem_code`, where base = `{cfg_dmem_base, 12'h000}`. The location is (address - base) modulo 2^D_AW.
- R4: A data access that hits both regions is served by the instruction memory. Writes through the data port land in the instruction memory and can be fetched afterwards.
- R5: A fetch consults only the instruction region and never hits the data region. `if_word`=1 returns the whole aligned word. `if_word`=0 returns the halfword selected by address bit 1 (1 = bits 31:16), zero-extended.
- R6: `d_size` selects the access width: 0 = byte, 1 = halfword, 2 = word. Lanes are little-endian and naturally aligned: a byte uses lane `addr[1:0]`, a halfword uses lanes selected by `addr[1]`. Read data is right-justified and zero-extended. A write changes only the selected lanes.
- R7: Every accepted request raises its response valid exactly one cycle later, with the hit flag. A miss returns zero data and a missed write changes no memory. Data-port writes return zero data.
- R8: A disabled region never hits, whatever its base and size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cfg_imem_en | input | 1 | instruction region enable |
| cfg_imem_code | input | 5 | instruction region size code |
| cfg_dmem_en | input | 1 | data region enable |
| cfg_dmem_base | input | 20 | data region base, address bits 31:12 |
| cfg_dmem_code | input | 5 | data region size code |
| init_done | output | 1 | zero-fill finished, requests accepted |
| if_req | input | 1 | fetch request |
| if_addr | input | 32 | fetch byte address |
| if_word | input | 1 | 1 = word fetch, 0 = halfword fetch |
| if_rsp_valid | output | 1 | fetch response valid |
| if_rsp_hit | output | 1 | fetch hit the instruction memory |
| if_rsp_data | output | 32 | fetch data |
| d_req | input | 1 | data request |
| d_we | input | 1 | 1 = write |
| d_size | input | 2 | access width code |
| d_addr | input | 32 | data byte address |
| d_wdata | input | 32 | write data, right-justified |
| d_rsp_valid | output | 1 | data response valid |
| d_rsp_hit | output | 1 | data access hit a memory |
| d_rsp_data | output | 32 | read data |

## Verification
On every cycle the assertions check these timing properties:
- responses follow accepted requests by one cycle;
- nothing responds or completes before initialisation ends;
- `init_done` never falls;
- misses carry zero data;
- a fetch hit implies that the region was enabled.

Only the bench's scenarios can show the address arithmetic and data behaviour:
- the mirroring and the data offset wrap;
- the exact region boundaries;
- the overlap priority;
- lane placement for the byte and halfword widths;
- that a missed write leaves memory untouched.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_size_e;

    // region length in bytes for a size code; saturates at 4 GiB
    function automatic logic [32:0] region_bytes(input logic [4:0] code);
        if (code >= 5'd23) return 33'h1_0000_0000;
        return 33'd512 << code;
    endfunction

    function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
        case (sz)
            ACC_BYTE: return 4'b0001 << lo;
            ACC_HALF: return lo[1] ? 4'b1100 : 4'b0011;
            default:  return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] place_wdata(input logic [1:0] sz, input logic [31:0] v);
        case (sz)
            ACC_BYTE: return {4{v[7:0]}};
            ACC_HALF: return {2{v[15:0]}};
            default:  return v;
        endcase
    endfunction

    function automatic logic [31:0] pick_rdata(input logic [1:0] sz, input logic [1:0] lo,
                                               input logic [31:0] w);
        logic [31:0] sh;
        sh = w >> {lo, 3'b000};
        case (sz)
            ACC_BYTE: return {24'h0, sh[7:0]};
            ACC_HALF: return lo[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
            default:  return w;
        endcase
    endfunction

endpackage

// File: rtl/tcm_region_decode.sv
module tcm_region_decode #(
    parameter int AW = 12
) (
    input  logic [31:0]   addr,
    input  logic          en,
    input  logic [31:0]   base,
    input  logic [4:0]    code,
    output logic          hit,
    output logic [AW-3:0] widx
);
    import tcm_pkg::*;

    logic [33:0] lim;
    logic [31:0] off;
    logic        unused_off_bits;

    always_comb begin
        lim  = {2'b00, base} + {1'b0, region_bytes(code)};
        off  = addr - base;
        hit  = en && (addr >= base) && ({2'b00, addr} < lim);
        widx = off[AW-1:2];
    end

    assign unused_off_bits = ^{off[31:AW], off[1:0]};

endmodule

// File: rtl/tcm_ram.sv
module tcm_ram #(
    parameter int AW        = 12,
    parameter bit DUAL_READ = 1'b1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-3:0] wr_idx,
    input  logic [3:0]    wr_be,
    input  logic [31:0]   wr_data,
    input  logic          ra_en,
    input  logic [AW-3:0] ra_idx,
    output logic [31:0]   ra_data,
    input  logic          rb_en,
    input  logic [AW-3:0] rb_idx,
    output logic [31:0]   rb_data
);
    localparam int WORDS = 1 << (AW - 2);

    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] lane_mem [WORDS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[g]) lane_mem[wr_idx] <= wr_data[g*8 +: 8];
            if (ra_en) ra_data[g*8 +: 8] <= lane_mem[ra_idx];
        end

        if (DUAL_READ) begin : g_rb
            always_ff @(posedge clk) begin
                if (rb_en) rb_data[g*8 +: 8] <= lane_mem[rb_idx];
            end
        end else begin : g_no_rb
            assign rb_data[g*8 +: 8] = 8'h00;
        end
    end

    if (!DUAL_READ) begin : g_rb_tie
        logic unused_rb;
        assign unused_rb = ^{rb_en, rb_idx};
    end

endmodule

// File: rtl/tcm_router.sv
module tcm_router #(
    parameter int I_AW = 12,
    parameter int D_AW = 11
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_imem_en,
    input  logic [4:0]  cfg_imem_code,
    input  logic        cfg_dmem_en,
    input  logic [19:0] cfg_dmem_base,
    input  logic [4:0]  cfg_dmem_code,
    output logic        init_done,
    input  logic        if_req,
    input  logic [31:0] if_addr,
    input  logic        if_word,
    output logic        if_rsp_valid,
    output logic        if_rsp_hit,
    output logic [31:0] if_rsp_data,
    input  logic        d_req,
    input  logic        d_we,
    input  logic [1:0]  d_size,
    input  logic [31:0] d_addr,
    input  logic [31:0] d_wdata,
    output logic        d_rsp_valid,
    output logic        d_rsp_hit,
    output logic [31:0] d_rsp_data
);
    import tcm_pkg::*;

    localparam int IW = I_AW - 2;
    localparam int DW = D_AW - 2;
    localparam int CW = (IW > DW) ? IW : DW;

    typedef struct packed {
        logic [CW-1:0] clr_cnt;
        logic          done;
        logic          f_v;
        logic          f_hit;
        logic          f_word;
        logic          f_hi;
        logic          d_v;
        logic          d_hit;
        logic          d_rd;
        logic          d_src_i;
        logic [1:0]    d_sz;
        logic [1:0]    d_lo;
    } st_t;

    st_t st_d, st_q;

    logic          f_hit, di_hit, dd_hit;
    logic [IW-1:0] f_widx, di_widx;
    logic [DW-1:0] dd_widx;
    logic [31:0]   dmem_base;

    logic          i_we, d_wen, i_ra_en, i_rb_en, d_rd_en;
    logic [IW-1:0] i_widx;
    logic [DW-1:0] d_widx;
    logic [3:0]    be;
    logic [31:0]   wv;
    logic [31:0]   i_ra, i_rb, d_rb, dmem_unused_rd;
    logic          f_go, d_go, to_i, to_d;

    assign dmem_base = {cfg_dmem_base, 12'h000};

    tcm_region_decode #(.AW(I_AW)) u_dec_fetch (
        .addr(if_addr), .en(cfg_imem_en), .base(32'h0), .code(cfg_imem_code),
        .hit(f_hit), .widx(f_widx));

    tcm_region_decode #(.AW(I_AW)) u_dec_data_i (
        .addr(d_addr), .en(cfg_imem_en), .base(32'h0), .code(cfg_imem_code),
        .hit(di_hit), .widx(di_widx));

    tcm_region_decode #(.AW(D_AW)) u_dec_data_d (
        .addr(d_addr), .en(cfg_dmem_en), .base(dmem_base), .code(cfg_dmem_code),
        .hit(dd_hit), .widx(dd_widx));

    always_comb begin
        st_d = st_q;
        f_go = if_req && st_q.done;
        d_go = d_req && st_q.done;
        to_i = di_hit;
        to_d = !di_hit && dd_hit;
        be   = st_q.done ? lane_mask(d_size, d_addr[1:0]) : 4'hF;
        wv   = st_q.done ? place_wdata(d_size, d_wdata) : 32'h0;

        i_we    = !st_q.done || (d_go && d_we && to_i);
        d_wen   = !st_q.done || (d_go && d_we && to_d);
        i_widx  = st_q.done ? di_widx : st_q.clr_cnt[IW-1:0];
        d_widx  = st_q.done ? dd_widx : st_q.clr_cnt[DW-1:0];
        i_ra_en = f_go && f_hit;
        i_rb_en = d_go && !d_we && to_i;
        d_rd_en = d_go && !d_we && to_d;

        if (!st_q.done) begin
            st_d.clr_cnt = st_q.clr_cnt + 1'b1;
            st_d.done    = &st_q.clr_cnt;
        end

        st_d.f_v     = f_go;
        st_d.f_hit   = f_go && f_hit;
        st_d.f_word  = if_word;
        st_d.f_hi    = if_addr[1];
        st_d.d_v     = d_go;
        st_d.d_hit   = d_go && (to_i || to_d);
        st_d.d_rd    = !d_we;
        st_d.d_src_i = to_i;
        st_d.d_sz    = d_size;
        st_d.d_lo    = d_addr[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tcm_ram #(.AW(I_AW), .DUAL_READ(1'b1)) u_imem (
        .clk(clk), .wr_en(i_we), .wr_idx(i_widx), .wr_be(be), .wr_data(wv),
        .ra_en(i_ra_en), .ra_idx(f_widx), .ra_data(i_ra),
        .rb_en(i_rb_en), .rb_idx(di_widx), .rb_data(i_rb));

    tcm_ram #(.AW(D_AW), .DUAL_READ(1'b0)) u_dmem (
        .clk(clk), .wr_en(d_wen), .wr_idx(d_widx), .wr_be(be), .wr_data(wv),
        .ra_en(d_rd_en), .ra_idx(dd_widx), .ra_data(d_rb),
        .rb_en(1'b0), .rb_idx(dd_widx), .rb_data(dmem_unused_rd));

    always_comb begin
        init_done    = st_q.done;
        if_rsp_valid = st_q.f_v;
        if_rsp_hit   = st_q.f_hit;
        if (!st_q.f_hit)     if_rsp_data = 32'h0;
        else if (st_q.f_word) if_rsp_data = i_ra;
        else                 if_rsp_data = st_q.f_hi ? {16'h0, i_ra[31:16]} : {16'h0, i_ra[15:0]};
        d_rsp_valid = st_q.d_v;
        d_rsp_hit   = st_q.d_hit;
        d_rsp_data  = (st_q.d_hit && st_q.d_rd)
                    ? pick_rdata(st_q.d_sz, st_q.d_lo, st_q.d_src_i ? i_rb : d_rb) : 32'h0;
    end

    // response timing against the request ports
    p_fetch_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        if_req && init_done |=> if_rsp_valid);
    p_data_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        d_rsp_valid |-> $past(d_req) && $past(init_done));
    p_quiet_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |=> !if_rsp_valid && !d_rsp_valid);
    p_done_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (if_rsp_valid && !if_rsp_hit) |-> (if_rsp_data == 32'h0));
    p_fetch_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (if_rsp_valid && if_rsp_hit) |-> $past(cfg_imem_en));

endmodule

// File: tb/tb_tcm_router.sv
module tb_tcm_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_imem_en = 1'b1;
    logic [4:0]  cfg_imem_code = 5'd3;
    logic        cfg_dmem_en = 1'b0;
    logic [19:0] cfg_dmem_base = 20'h0;
    logic [4:0]  cfg_dmem_code = 5'd0;
    logic        init_done;
    logic        if_req = 1'b0, if_word = 1'b1;
    logic [31:0] if_addr = 32'h0;
    logic        if_rsp_valid, if_rsp_hit;
    logic [31:0] if_rsp_data;
    logic        d_req = 1'b0, d_we = 1'b0;
    logic [1:0]  d_size = 2'd2;
    logic [31:0] d_addr = 32'h0, d_wdata = 32'h0;
    logic        d_rsp_valid, d_rsp_hit;
    logic [31:0] d_rsp_data;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    tcm_router dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic fetch(input logic [31:0] a, input logic w, output logic hit, output logic [31:0] dat);
        @(negedge clk);
        if_req = 1'b1; if_addr = a; if_word = w;
        @(negedge clk);
        if_req = 1'b0;
        check("R7 fetch valid", {31'h0, if_rsp_valid}, 32'h1);
        hit = if_rsp_hit; dat = if_rsp_data;
    endtask

    task automatic dacc(input logic we, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, output logic hit, output logic [31:0] dat);
        @(negedge clk);
        d_req = 1'b1; d_we = we; d_size = sz; d_addr = a; d_wdata = wd;
        @(negedge clk);
        d_req = 1'b0; d_we = 1'b0;
        check("R7 data valid", {31'h0, d_rsp_valid}, 32'h1);
        hit = d_rsp_hit; dat = d_rsp_data;
    endtask

    task automatic t_init();
        logic h; logic [31:0] v;
        repeat (3) @(negedge clk);
        check("R1 init low", {31'h0, init_done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        if_req = 1'b1; if_addr = 32'h0; d_req = 1'b1; d_we = 1'b1; d_addr = 32'h4; d_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        if_req = 1'b0; d_req = 1'b0; d_we = 1'b0;
        check("R1 no rsp in init", {30'h0, if_rsp_valid, d_rsp_valid}, 32'h0);
        while (!init_done) @(negedge clk);
        check("R1 done stays", {31'h0, init_done}, 32'h1);
        fetch(32'h4, 1'b1, h, v);
        check("R1 zero fill hit", {31'h0, h}, 32'h1);
        check("R1 zero fill data", v, 32'h0);
    endtask

    task automatic t_mirror();
        logic h; logic [31:0] v;
        cfg_imem_code = 5'd4;                       // 8 KiB region over 4 KiB memory
        dacc(1'b1, 2'd2, 32'h10, 32'hCAFE_F00D, h, v);
        check("R7 write hit", {31'h0, h}, 32'h1);
        check("R7 write data zero", v, 32'h0);
        fetch(32'h1010, 1'b1, h, v);
        check("R2 mirror data", v, 32'hCAFE_F00D);
        fetch(32'h1FFC, 1'b1, h, v);
        check("R2 last word hit", {31'h0, h}, 32'h1);
        fetch(32'h2000, 1'b1, h, v);
        check("R2 end miss", {31'h0, h}, 32'h0);
        check("R7 miss zero", v, 32'h0);
        fetch(32'h12, 1'b0, h, v);
        check("R5 upper half", v, 32'h0000_CAFE);
        fetch(32'h10, 1'b0, h, v);
        check("R5 lower half", v, 32'h0000_F00D);
    endtask

    task automatic t_data();
        logic h; logic [31:0] v;
        cfg_dmem_en = 1'b1; cfg_dmem_base = 20'h00800; cfg_dmem_code = 5'd3;   // 4 KiB
        dacc(1'b1, 2'd2, 32'h0080_0020, 32'h1122_3344, h, v);
        dacc(1'b1, 2'd0, 32'h0080_0021, 32'h0000_00AA, h, v);
        dacc(1'b0, 2'd2, 32'h0080_0020, 32'h0, h, v);
        check("R6 byte lane write", v, 32'h1122_AA44);
        dacc(1'b0, 2'd1, 32'h0080_0022, 32'h0, h, v);
        check("R6 half read", v, 32'h0000_1122);
        dacc(1'b0, 2'd0, 32'h0080_0021, 32'h0, h, v);
        check("R6 byte read", v, 32'h0000_00AA);
        dacc(1'b1, 2'd1, 32'h0080_0022, 32'h0000_BEEF, h, v);
        dacc(1'b0, 2'd2, 32'h0080_0820, 32'h0, h, v);
        check("R3 offset wrap", v, 32'hBEEF_AA44);
        dacc(1'b0, 2'd2, 32'h007F_FFFC, 32'h0, h, v);
        check("R3 below base miss", {31'h0, h}, 32'h0);
        dacc(1'b0, 2'd2, 32'h0080_0FFC, 32'h0, h, v);
        check("R3 last word hit", {31'h0, h}, 32'h1);
        dacc(1'b1, 2'd2, 32'h0080_1020, 32'h5555_5555, h, v);
        check("R3 end miss", {31'h0, h}, 32'h0);
        dacc(1'b0, 2'd2, 32'h0080_0020, 32'h0, h, v);
        check("R7 missed write no effect", v, 32'hBEEF_AA44);
        fetch(32'h0080_0020, 1'b1, h, v);
        check("R5 fetch ignores data region", {31'h0, h}, 32'h0);
    endtask

    task automatic t_priority();
        logic h; logic [31:0] v;
        cfg_dmem_base = 20'h0; cfg_dmem_code = 5'd4;
        dacc(1'b1, 2'd2, 32'h100, 32'h55AA_55AA, h, v);
        fetch(32'h100, 1'b1, h, v);
        check("R4 overlap to imem", v, 32'h55AA_55AA);
        cfg_imem_en = 1'b0;
        dacc(1'b0, 2'd2, 32'h100, 32'h0, h, v);
        check("R4 dmem hit after imem off", {31'h0, h}, 32'h1);
        check("R4 dmem untouched", v, 32'h0);
        fetch(32'h100, 1'b1, h, v);
        check("R8 imem off miss", {31'h0, h}, 32'h0);
        cfg_dmem_en = 1'b0;
        dacc(1'b0, 2'd2, 32'h100, 32'h0, h, v);
        check("R8 dmem off miss", {31'h0, h}, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_init();
        t_mirror();
        t_data();
        t_priority();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule